// File: doc/BRIEF.md
# ALU Status Flag Generator

This block keeps the condition flags of a 16-bit processor status word. After each ALU operation the datapath gives it the 17-bit result of the add or subtract (bit 16 is the carry out), the two 16-bit operands, and a two-bit update mode. From these it works out negative, zero, signed-compare and carry flags and merges them into the held status word. The signed-compare flag is the carry out XORed with the difference of the operand signs. It is not a plain two's-complement overflow flag.

Arithmetic operations rewrite all four flags. Logical, load and test operations rewrite only negative and zero, and the other two keep their values. A hold mode leaves the word untouched. A write mode loads the whole word from the first operand, which is how the core restores a saved status word. The next flag values are given out combinationally in the same cycle. The registered status word follows them on the next clock edge.

Top module: `flag_unit`

## Requirements
- R1: After reset is released, `stat_q` reads 0x0000, and in hold mode `flags_nxt` reads 0.
- R2: In NZ mode (`mode`=1) and arithmetic mode (`mode`=2), the N flag (status bit 3) becomes `res[15]`.
- R3: In modes 1 and 2, the Z flag (status bit 2) becomes 1 exactly when `res[15:0]` is zero. `res[16]` has no effect on Z.
- R4: In arithmetic mode, the C flag (status bit 0) becomes `res[16]`.
- R5: In arithmetic mode, the S flag (status bit 1) becomes `res[16] ^ (op_a[15] ^ op_b[15])`.
- R6: In NZ mode, S and C keep their previous values whatever `res`, `op_a` and `op_b` are.
- R7: An arithmetic update replaces all four flags with the new values. A flag that was 1 before and is computed as 0 reads 0 afterwards.
- R8: In hold mode (`mode`=0), `stat_q` does not change on the clock edge, and `flags_nxt` equals the flag bits now held.
- R9: In modes 1 and 2, status bits 15..4 pass through unchanged.
- R10: In write mode (`mode`=3), `stat_q` takes the value of `op_a` on the next edge.
- R11: `flags_nxt` is packed {N,Z,S,C} (bit 3 down to bit 0). It equals the flag bits that `stat_q` holds after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode | input | 2 | 0 hold, 1 update N/Z, 2 update all flags, 3 load whole word |
| res | input | 17 | ALU result; bit 16 is the carry out |
| op_a | input | 16 | First ALU operand; also the load value in write mode |
| op_b | input | 16 | Second ALU operand |
| flags_nxt | output | 4 | Next flags {N,Z,S,C}, combinational |
| stat_q | output | 16 | Registered status word |

## Verification
The bench drives a 17-bit result of 0x10000, so the low half is zero while the carry is set. A design that reduced all 17 bits for Z would miss the zero, and one that used bit 16 for N would report a negative. It runs arithmetic updates both with equal operand signs and with different operand signs at the same carry. This tells the signed-compare flag apart from a copied carry, a plain overflow formula or a reversed sign term. It also loads all-ones into the word before an arithmetic update that should clear every flag. That exposes OR-ing into stale flags and any disturbance of the upper twelve bits. NZ updates with a carry in the result, and hold cycles with changing inputs, show whether S and C are wrongly rewritten or the word drifts.

// File: rtl/flagcore_pkg.sv
package flagcore_pkg;

  typedef enum logic [1:0] {
    FM_HOLD  = 2'd0,
    FM_NZ    = 2'd1,
    FM_ARITH = 2'd2,
    FM_WRITE = 2'd3
  } fmode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic s;
    logic c;
  } flags_t;

  localparam int FLAG_CNT = 4;

endpackage

// File: rtl/fu_rst_sync.sv
module fu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fu_flag_calc.sv
module fu_flag_calc
  import flagcore_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  fmode_e            mode,
  input  logic [DATA_W:0]   res,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  flags_t            cur,
  output flags_t            nxt
);

  localparam int MSB = DATA_W - 1;

  logic raw_n;
  logic raw_z;
  logic raw_s;
  logic raw_c;

  always_comb begin
    raw_n = res[MSB];
    raw_z = ~|res[MSB:0];
    raw_c = res[DATA_W];
    raw_s = res[DATA_W] ^ (op_a[MSB] ^ op_b[MSB]);
  end

  always_comb begin
    nxt = cur;
    unique case (mode)
      FM_NZ: begin
        nxt.n = raw_n;
        nxt.z = raw_z;
      end
      FM_ARITH: begin
        nxt   = '0;
        nxt.n = raw_n;
        nxt.z = raw_z;
        nxt.s = raw_s;
        nxt.c = raw_c;
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/fu_stat_reg.sv
module fu_stat_reg
  import flagcore_pkg::*;
#(
  parameter int SR_W  = 16,
  parameter int POS_N = 3,
  parameter int POS_Z = 2,
  parameter int POS_S = 1,
  parameter int POS_C = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  fmode_e          mode,
  input  flags_t          nxt,
  input  logic [SR_W-1:0] load_val,
  output logic [SR_W-1:0] stat_d,
  output logic [SR_W-1:0] stat_q
);

  logic stat_en;

  always_comb begin
    stat_d = stat_q;
    if (mode == FM_WRITE) begin
      stat_d = load_val;
    end else begin
      stat_d[POS_N] = nxt.n;
      stat_d[POS_Z] = nxt.z;
      stat_d[POS_S] = nxt.s;
      stat_d[POS_C] = nxt.c;
    end
    stat_en = (mode != FM_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_HOLD) |=> $stable(stat_q)); // R8

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_WRITE) |=> (stat_q == $past(load_val))); // R10

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flagcore_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SYNC_STG = 2,
  parameter int POS_N    = 3,
  parameter int POS_Z    = 2,
  parameter int POS_S    = 1,
  parameter int POS_C    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [DATA_W:0]   res,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [FLAG_CNT-1:0] flags_nxt,
  output logic [DATA_W-1:0] stat_q
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << POS_N) | (DATA_W'(1) << POS_Z) |
    (DATA_W'(1) << POS_S) | (DATA_W'(1) << POS_C);

  logic              rst_n_i;
  fmode_e            mode_e;
  flags_t            cur_f;
  flags_t            nxt_f;
  logic [DATA_W-1:0] stat_d;

  assign mode_e = fmode_e'(mode);

  fu_rst_sync #(
    .STAGES(SYNC_STG)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    cur_f.n = stat_q[POS_N];
    cur_f.z = stat_q[POS_Z];
    cur_f.s = stat_q[POS_S];
    cur_f.c = stat_q[POS_C];
  end

  fu_flag_calc #(
    .DATA_W(DATA_W)
  ) u_calc (
    .mode(mode_e),
    .res (res),
    .op_a(op_a),
    .op_b(op_b),
    .cur (cur_f),
    .nxt (nxt_f)
  );

  fu_stat_reg #(
    .SR_W (DATA_W),
    .POS_N(POS_N),
    .POS_Z(POS_Z),
    .POS_S(POS_S),
    .POS_C(POS_C)
  ) u_sreg (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .mode    (mode_e),
    .nxt     (nxt_f),
    .load_val(op_a),
    .stat_d  (stat_d),
    .stat_q  (stat_q)
  );

  assign flags_nxt = {stat_d[POS_N], stat_d[POS_Z], stat_d[POS_S], stat_d[POS_C]};

  AST_N_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode == 2'd1 || mode == 2'd2) |=> (stat_q[POS_N] == $past(res[MSB]))); // R2

  AST_Z_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode == 2'd1 || mode == 2'd2) |=> (stat_q[POS_Z] == ($past(res[MSB:0]) == '0))); // R3

  AST_C_CARRY: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode == 2'd2) |=> (stat_q[POS_C] == $past(res[DATA_W]))); // R4

  AST_S_SIGNED: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode == 2'd2) |=> (stat_q[POS_S] ==
      ($past(res[DATA_W]) ^ $past(op_a[MSB]) ^ $past(op_b[MSB])))); // R5

  AST_NZ_KEEPS_SC: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode == 2'd1) |=> ($stable(stat_q[POS_S]) && $stable(stat_q[POS_C]))); // R6

  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode == 2'd1 || mode == 2'd2) |=> ((stat_q & ~FLAG_MASK) == $past(stat_q & ~FLAG_MASK))); // R9

  AST_NXT_MATCH: assert property (@(posedge clk) disable iff (!rst_n_i)
    1'b1 |=> ($past(flags_nxt) ==
      {stat_q[POS_N], stat_q[POS_Z], stat_q[POS_S], stat_q[POS_C]})); // R11

endmodule

// File: tb/test_flag_unit.sv
`timescale 1ns/100ps
module test_flag_unit;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [16:0] res;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic [3:0]  flags_nxt;
  logic [15:0] stat_q;

  int n_chk;
  int n_bad;
  logic [15:0] model_sr;

  flag_unit i_flag_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .res      (res),
    .op_a     (op_a),
    .op_b     (op_b),
    .flags_nxt(flags_nxt),
    .stat_q   (stat_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [15:0] expect_sr(input logic [1:0] m, input logic [15:0] sr,
                                            input logic [16:0] r, input logic [15:0] a,
                                            input logic [15:0] b);
    logic [15:0] e;
    e = sr;
    case (m)
      2'd1: begin
        e[3] = r[15];
        e[2] = (r[15:0] == 16'h0000);
      end
      2'd2: begin
        e[3] = r[15];
        e[2] = (r[15:0] == 16'h0000);
        e[1] = r[16] ^ a[15] ^ b[15];
        e[0] = r[16];
      end
      2'd3: e = a;
      default: e = sr;
    endcase
    return e;
  endfunction

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] m, input logic [16:0] r,
                      input logic [15:0] a, input logic [15:0] b);
    logic [15:0] e;
    @(negedge clk);
    mode = m; res = r; op_a = a; op_b = b;
    e = expect_sr(m, model_sr, r, a, b);
    #1;
    chk16({tag, " R11 flags_nxt"}, {12'h000, flags_nxt}, {12'h000, e[3:0]});
    @(posedge clk);
    #1;
    chk16({tag, " stat_q"}, stat_q, e);
    model_sr = e;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    mode = 2'd0; res = '0; op_a = '0; op_b = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    model_sr = 16'h0000;
    chk16("R1 stat_q after reset", stat_q, 16'h0000);
    chk16("R1 flags_nxt after reset", {12'h000, flags_nxt}, 16'h0000);
  endtask

  task automatic t_arith;
    step("R2 R5 negative, signs differ", 2'd2, 17'h0_8000, 16'h8000, 16'h0000);
    step("R3 R4 low half zero with carry", 2'd2, 17'h1_0000, 16'hFFFF, 16'h0001);
    step("R3 zero without carry", 2'd2, 17'h0_0000, 16'h1234, 16'h1234);
    step("R5 carry, signs differ", 2'd2, 17'h1_7FFF, 16'h8000, 16'h7FFF);
    step("R5 carry, signs equal", 2'd2, 17'h1_7FFF, 16'h0000, 16'h7FFF);
    step("R5 no carry, both negative", 2'd2, 17'h0_0001, 16'h8000, 16'hFFFF);
  endtask

  task automatic t_clear;
    step("R10 load all ones", 2'd3, 17'h0_0000, 16'hFFFF, 16'h0000);
    step("R7 R9 arith clears stale flags", 2'd2, 17'h0_0001, 16'h0000, 16'h0000);
    chk16("R7 exact word", stat_q, 16'hFFF0);
  endtask

  task automatic t_nz;
    step("R10 preset S and C", 2'd3, 17'h0_0000, 16'h0003, 16'h0000);
    step("R6 NZ keeps S,C", 2'd1, 17'h1_0000, 16'h8000, 16'h0000);
    chk16("R6 word", stat_q, 16'h0007);
    step("R10 clear", 2'd3, 17'h0_0000, 16'h0000, 16'h0000);
    step("R6 NZ ignores carry", 2'd1, 17'h1_8000, 16'h8000, 16'h0000);
    chk16("R2 R6 word", stat_q, 16'h0008);
  endtask

  task automatic t_hold;
    step("R10 preset", 2'd3, 17'h0_0000, 16'h3C0A, 16'h0000);
    step("R8 hold 1", 2'd0, 17'h1_0000, 16'hFFFF, 16'h0000);
    step("R8 hold 2", 2'd0, 17'h0_8001, 16'h0000, 16'h8000);
    chk16("R8 word", stat_q, 16'h3C0A);
  endtask

  task automatic t_write_pass;
    step("R10 load pattern", 2'd3, 17'h1_FFFF, 16'hA5C3, 16'hFFFF);
    chk16("R10 word", stat_q, 16'hA5C3);
    step("R9 arith keeps upper", 2'd2, 17'h0_4000, 16'h0000, 16'h0000);
    chk16("R9 word", stat_q, 16'hA5C0);
    step("R9 NZ keeps upper", 2'd1, 17'h0_0000, 16'h0000, 16'h0000);
    chk16("R9 NZ word", stat_q, 16'hA5C4);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    model_sr = '0;
    t_reset();
    t_arith();
    t_clear();
    t_nz();
    t_hold();
    t_write_pass();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule